// File: doc/BRIEF.md
# RMII Receive Di-bit Output Stage

This block is the last stage of a PHY receive path on a Reduced MII port. An internal receive path hands it whole bytes with a strobe, together with a carrier indication and a false-carrier flag. The stage puts the bytes into a small FIFO and sends them out as two-bit symbols on `rxd`, timed by the 50 MHz reference clock. It also drives the combined carrier-sense/data-valid output `crs_dv`.

Two line rates are supported. At 100 Mb/s a new di-bit appears on every clock. At 10 Mb/s every di-bit is held for ten clocks. When the carrier ends while bytes are still buffered, `crs_dv` drops on the first di-bit of each byte and comes back on the second one. This tells the MAC that valid data is still draining. Once the last buffered di-bit has been sent, `crs_dv` stays low. A false carrier is reported as a fixed symbol for as long as it lasts.

Top module: `rmii_rx_dibit_out`

## Requirements
- R1: While `rst_n` is low and on the first clock after it is released, `rxd` is 2'b00 and both `crs_dv` and `ovf_err` are 0.
- R2: Each byte leaves as four di-bits in this order: bits [1:0], [3:2], [5:4], [7:6]. Bytes follow one another with no gap, in the order they were accepted.
- R3: In 100 Mb/s mode (`speed_10` = 0 while idle) a new di-bit slot starts on every clock edge. The edge that first samples the carrier high is slot 0. Byte k, di-bit j is presented from edge 1+4k+j.
- R4: In 10 Mb/s mode (`speed_10` = 1 while idle) slot s starts on clock edge 10·s, counted from the edge where `crs_dv` rose. `rxd` and the data-valid level stay unchanged for the ten clocks of a slot.
- R5: `crs_dv` goes high on the first clock edge that samples `rx_carrier` high, in either mode, without waiting for a slot boundary.
- R6: `crs_dv` follows the carrier sampled at each slot boundary. When the carrier is low, `crs_dv` is still high on di-bit positions 1 to 3 of a byte being sent, and low on position 0. It falls only at a slot boundary, and it is low once no byte is being sent.
- R7: While `crs_dv` is high and no byte is available, `rxd` carries the fill symbol 2'b00.
- R8: In every slot whose starting edge samples both `rx_carrier` and `rx_false_carrier` high, `rxd` is 2'b10 and `crs_dv` is 1. The first slot with the carrier low returns to 2'b00 with `crs_dv` low when no data is buffered.
- R9: The FIFO holds FIFO_DEPTH bytes, 8 by default. A byte strobed while the FIFO is full sets `ovf_err`, which stays set until reset. That byte is dropped, and so is every later byte until an edge samples `rx_carrier` low.
- R10: `speed_10` is taken only while the stage is idle, meaning `crs_dv` is low, the FIFO is empty and no byte is being sent. Changing it during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_10 | input | 1 | 1 selects 10 Mb/s, 0 selects 100 Mb/s; taken while idle |
| rx_carrier | input | 1 | Receive medium non-idle |
| rx_false_carrier | input | 1 | Current carrier event is a false carrier |
| byte_valid | input | 1 | Strobe for one received byte |
| byte_data | input | 8 | Received byte |
| rxd | output | 2 | Receive di-bit |
| crs_dv | output | 1 | Carrier sense / receive data valid |
| ovf_err | output | 1 | Sticky FIFO overflow flag |

## Verification
The assertions assume three things about the inputs. `rx_false_carrier` is only raised together with `rx_carrier`. A frame's bytes arrive no slower than they drain. The carrier does not come back while a previous frame is still draining. The stimulus respects all three. Each frame pushes its bytes on consecutive clocks, starting at the edge where the carrier rises. False-carrier events carry no bytes. Every frame, random or directed, ends with an idle gap before the next carrier, and the line rate is only changed during that gap. The one exception is the directed case that changes the rate on purpose in the middle of a frame.

// File: rtl/rmii_rxo_pkg.sv
package rmii_rxo_pkg;
  localparam int BYTE_W  = 8;
  localparam int DIBIT_W = 2;
  localparam int SLOTS   = BYTE_W / DIBIT_W;
  localparam int SLOT_W  = $clog2(SLOTS);

  typedef logic [DIBIT_W-1:0] dibit_t;
  typedef logic [SLOT_W-1:0]  slot_t;

  localparam dibit_t FILL_SYM  = 2'b00;
  localparam dibit_t FALSE_SYM = 2'b10;
  localparam slot_t  LAST_SLOT = slot_t'(SLOTS - 1);

  // di-bit at slot position pos, lowest pair first
  function automatic dibit_t pick_dibit(input logic [BYTE_W-1:0] b, input slot_t pos);
    return b[{pos, 1'b0} +: DIBIT_W];
  endfunction

  // data-valid level for a slot: carrier, or mid-byte drain
  function automatic logic slot_valid(input logic carrier, input logic sending, input slot_t pos);
    return carrier | (sending & (pos != '0));
  endfunction
endpackage

// File: rtl/rxo_fifo.sv
module rxo_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxo_rate.sv
module rxo_rate #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  input  logic hold,
  output logic tick
);
  if (SLOW_DIV > 1) begin : g_div
    localparam int DW = $clog2(SLOW_DIV);
    localparam logic [DW-1:0] LAST = DW'(SLOW_DIV - 1);
    logic [DW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              div_q <= '0;
      else if (hold)           div_q <= '0;
      else if (div_q == LAST)  div_q <= '0;
      else                     div_q <= div_q + 1'b1;
    end

    assign tick = !slow || (div_q == LAST);
  end else begin : g_nodiv
    logic unused_ok;
    assign unused_ok = &{1'b0, slow, hold};
    assign tick = 1'b1;
  end
endmodule

// File: rtl/rxo_serial.sv
module rxo_serial
  import rmii_rxo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              carrier,
  input  logic              false_cr,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] fifo_rdata,
  output logic              pop,
  output dibit_t            rxd,
  output logic              crs_dv,
  output logic              sending,
  output slot_t             pos
);
  logic [BYTE_W-1:0] cur_q, cur_n;
  slot_t             pos_q, pos_n;
  logic              send_q, send_n;
  dibit_t            rxd_q, rxd_n;
  logic              crs_q, crs_n;
  logic              false_now, more_in_byte;

  assign false_now    = carrier & false_cr;
  assign more_in_byte = send_q && (pos_q != LAST_SLOT);
  assign pop          = tick && !false_now && !more_in_byte && !fifo_empty;

  always_comb begin
    cur_n  = cur_q;
    pos_n  = pos_q;
    send_n = send_q;
    rxd_n  = rxd_q;
    crs_n  = crs_q;
    if (tick) begin
      if (false_now) begin
        send_n = 1'b0;
        pos_n  = '0;
        rxd_n  = FALSE_SYM;
        crs_n  = 1'b1;
      end else if (more_in_byte) begin
        pos_n = pos_q + 1'b1;
        rxd_n = pick_dibit(cur_q, pos_n);
        crs_n = slot_valid(carrier, 1'b1, pos_n);
      end else if (!fifo_empty) begin
        cur_n  = fifo_rdata;
        pos_n  = '0;
        send_n = 1'b1;
        rxd_n  = pick_dibit(fifo_rdata, '0);
        crs_n  = slot_valid(carrier, 1'b1, '0);
      end else begin
        send_n = 1'b0;
        pos_n  = '0;
        rxd_n  = FILL_SYM;
        crs_n  = carrier;
      end
    end else if (carrier && !crs_q) begin
      crs_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      pos_q  <= '0;
      send_q <= 1'b0;
      rxd_q  <= FILL_SYM;
      crs_q  <= 1'b0;
    end else begin
      cur_q  <= cur_n;
      pos_q  <= pos_n;
      send_q <= send_n;
      rxd_q  <= rxd_n;
      crs_q  <= crs_n;
    end
  end

  assign rxd     = rxd_q;
  assign crs_dv  = crs_q;
  assign sending = send_q;
  assign pos     = pos_q;
endmodule

// File: rtl/rmii_rx_dibit_out.sv
module rmii_rx_dibit_out
  import rmii_rxo_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int SLOW_DIV   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_10,
  input  logic              rx_carrier,
  input  logic              rx_false_carrier,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [DIBIT_W-1:0] rxd,
  output logic              crs_dv,
  output logic              ovf_err
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  // named internal events
  logic              tick_w, idle_w, mode_slow_q;
  logic              fifo_empty, fifo_full, fifo_pop, fifo_push;
  logic [CNT_W-1:0]  fifo_count;
  logic [BYTE_W-1:0] fifo_rdata;
  logic              wr_attempt, overflow_w, drop_q, err_q;
  logic              in_data;
  slot_t             pos_w;

  assign idle_w     = !crs_dv && fifo_empty && !in_data;
  assign wr_attempt = byte_valid && !drop_q;
  assign overflow_w = wr_attempt && fifo_full;
  assign fifo_push  = wr_attempt && !fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_slow_q <= 1'b0;
      drop_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (idle_w) mode_slow_q <= speed_10;
      if (overflow_w)       drop_q <= 1'b1;
      else if (!rx_carrier) drop_q <= 1'b0;
      if (overflow_w) err_q <= 1'b1;
    end
  end

  assign ovf_err = err_q;

  rxo_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .wdata (byte_data),
    .rdata (fifo_rdata),
    .empty (fifo_empty),
    .full  (fifo_full),
    .count (fifo_count)
  );

  rxo_rate #(.SLOW_DIV(SLOW_DIV)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .slow  (mode_slow_q),
    .hold  (idle_w),
    .tick  (tick_w)
  );

  rxo_serial u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_w),
    .carrier    (rx_carrier),
    .false_cr   (rx_false_carrier),
    .fifo_empty (fifo_empty),
    .fifo_rdata (fifo_rdata),
    .pop        (fifo_pop),
    .rxd        (rxd),
    .crs_dv     (crs_dv),
    .sending    (in_data),
    .pos        (pos_w)
  );
endmodule

// File: rtl/rmii_rxo_checker.sv
module rmii_rxo_checker #(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             mode_slow,
  input logic             idle,
  input logic [1:0]       rxd,
  input logic             crs_dv,
  input logic             ovf_err,
  input logic             rx_carrier,
  input logic             rx_false_carrier,
  input logic             fifo_full,
  input logic             wr_attempt,
  input logic             in_data,
  input logic [1:0]       pos,
  input logic [CNT_W-1:0] fifo_count
);
  assert_hold_slow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_slow && !tick) |=> $stable(rxd));

  assert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!crs_dv && rx_carrier) |=> crs_dv);

  assert_fall_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crs_dv) |-> ((!in_data || pos == 2'd0) && !$past(rx_carrier)));

  assert_false_sym_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rx_carrier && rx_false_carrier) |=> (rxd == 2'b10 && crs_dv));

  assert_overflow_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_attempt && fifo_full) |=> ovf_err);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(mode_slow));

  always @(posedge clk) begin
    if (rst_n) begin
      assert_depth_R9: assert (int'(fifo_count) <= FIFO_DEPTH);
    end
  end
endmodule

bind rmii_rx_dibit_out rmii_rxo_checker #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .tick             (tick_w),
  .mode_slow        (mode_slow_q),
  .idle             (idle_w),
  .rxd              (rxd),
  .crs_dv           (crs_dv),
  .ovf_err          (ovf_err),
  .rx_carrier       (rx_carrier),
  .rx_false_carrier (rx_false_carrier),
  .fifo_full        (fifo_full),
  .wr_attempt       (wr_attempt),
  .in_data          (in_data),
  .pos              (pos_w),
  .fifo_count       (fifo_count)
);

// File: tb/rmii_rx_dibit_out_bench.sv
module rmii_rx_dibit_out_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       speed_10, rx_carrier, rx_false_carrier, byte_valid;
  logic [7:0] byte_data;
  logic [1:0] rxd;
  logic       crs_dv, ovf_err;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] fb [16];

  always #10 clk = ~clk;

  rmii_rx_dibit_out u_rmii_rx_dibit_out (
    .clk(clk), .rst_n(rst_n), .speed_10(speed_10), .rx_carrier(rx_carrier),
    .rx_false_carrier(rx_false_carrier), .byte_valid(byte_valid), .byte_data(byte_data),
    .rxd(rxd), .crs_dv(crs_dv), .ovf_err(ovf_err)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {crs_dv,rxd} act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // expected {crs_dv, rxd} for slot s of a frame keeping k bytes, carrier low from slot d
  function automatic logic [2:0] exp_slot(input int s, input int k, input int d);
    if (s == 0) return {1'b1, 2'b00};
    if (s <= 4 * k) begin
      int kb = (s - 1) / 4;
      int j  = (s - 1) % 4;
      logic [1:0] sym = fb[kb][2*j +: 2];
      return {((s < d) || (j != 0)), sym};
    end
    return {(s < d), 2'b00};
  endfunction

  function automatic string slot_tag(input int s, input int k, input int d, input bit slow);
    if (s == 0) return "R5";
    if (s <= 4 * k) begin
      if (s >= d) return "R6";
      return slow ? "R4" : "R2/R3";
    end
    return (s < d) ? "R7" : "R6";
  endfunction

  // one frame: n bytes pushed from edge 0, k of them expected out; flip_at >= 0 toggles speed (R10)
  task automatic run_frame(input bit slow, input int n, input int d, input int k, input int flip_at);
    int p = slow ? 10 : 1;
    int last = ((4 * k + 1 > d) ? 4 * k + 1 : d) + 1;
    speed_10 = slow;
    rx_carrier = 0; rx_false_carrier = 0; byte_valid = 0; byte_data = 0;
    repeat (2) @(negedge clk);
    for (int c = 0; c < (last + 1) * p; c++) begin
      rx_carrier = (c < d * p);
      if (c < n) begin byte_valid = 1; byte_data = fb[c]; end
      else begin byte_valid = 0; byte_data = 8'h00; end
      if (c == flip_at) speed_10 = !slow;
      @(posedge clk);
      @(negedge clk);
      chk((flip_at >= 0) ? "R10" : slot_tag(c / p, k, d, slow), {crs_dv, rxd}, exp_slot(c / p, k, d));
    end
    rx_carrier = 0; byte_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_false(input int len);
    speed_10 = 0; rx_carrier = 0; rx_false_carrier = 0; byte_valid = 0;
    repeat (2) @(negedge clk);
    for (int c = 0; c < len + 2; c++) begin
      rx_carrier = (c < len);
      rx_false_carrier = (c < len);
      @(posedge clk);
      @(negedge clk);
      chk("R8", {crs_dv, rxd}, (c < len) ? 3'b110 : 3'b000);
    end
    rx_false_carrier = 0;
  endtask

  initial begin
    void'($urandom(32'd20240917));
    rst_n = 0; speed_10 = 0; rx_carrier = 0; rx_false_carrier = 0;
    byte_valid = 0; byte_data = 0;
    repeat (3) @(negedge clk);
    chk("R1", {crs_dv, rxd}, 3'b000);
    chk("R1", {2'b00, ovf_err}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {crs_dv, rxd}, 3'b000);

    // directed: byte order E4 -> 00,01,10,11 ; early carrier drop shows the toggling
    fb[0] = 8'hE4; fb[1] = 8'h1B;
    run_frame(0, 2, 3, 2, -1);
    run_frame(0, 2, 20, 2, -1);
    fb[0] = 8'h5A;
    run_frame(1, 1, 2, 1, -1);
    // no bytes at all: fill symbol only
    run_frame(0, 0, 5, 0, -1);
    // speed change mid frame must not alter the running frame
    for (int i = 0; i < 4; i++) fb[i] = 8'(8'h31 * (i + 1));
    run_frame(0, 4, 6, 4, 3);
    run_frame(1, 2, 3, 2, 15);
    run_false(7);
    run_false(1);

    // random frames
    for (int f = 0; f < 24; f++) begin
      bit slow = ($urandom % 4) == 0;
      int n = 1 + ($urandom % 8);
      int d = 1 + ($urandom % (4 * n + 4));
      for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
      run_frame(slow, n, d, n, -1);
    end
    chk("R9", {2'b00, ovf_err}, 3'b000);

    // overflow: 12 bytes at 10 Mb/s, only the first 8 fit
    for (int i = 0; i < 12; i++) fb[i] = 8'(8'hA0 + i);
    run_frame(1, 12, 40, 8, -1);
    chk("R9", {2'b00, ovf_err}, 3'b001);
    run_frame(0, 1, 2, 1, -1);
    chk("R9", {2'b00, ovf_err}, 3'b001);

    rst_n = 0;
    @(negedge clk);
    chk("R1", {crs_dv, rxd}, 3'b000);
    chk("R1", {2'b00, ovf_err}, 3'b000);
    rst_n = 1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1..: act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule